// File: doc/BRIEF.md
# Write-Protect Command Sequence Detector

This block sits in front of the write port of a byte-wide nonvolatile memory. It watches every latched write cycle, each given as an address and a data byte. For each one it decides in the same cycle whether the byte may reach the array. A protection flag, which stands in for a nonvolatile bit, decides what ordinary writes may do. While the flag is clear, they pass. While it is set, they are blocked.

Two fixed handshakes control the flag, and the block consumes them without storing them. A three-write arming handshake sets the flag and opens a single page-load window of up to `PAGE_BYTES` bytes. That window stays open until the array reports that its programming cycle has finished. A six-write handshake clears the flag. The handshakes must arrive as consecutive write cycles, because any foreign write abandons the handshake in progress.

Top module: `wp_seq_guard`

## Requirements
- R1: After reset the protection flag `prot_flag` is 0 and no load window is open.
- R2: With `prot_flag` at 0 and no window open, an ordinary write (one that does not advance a handshake) raises `wr_permit` in the same cycle as `wr_valid`. `wr_permit` is never high without `wr_valid`.
- R3: The consecutive writes AA to 1555, then 55 to 0AAA, then A0 to 1555 (all hex, data on `wr_data[7:0]`, address on `wr_addr[12:0]`) set `prot_flag` on the clock edge that takes the third write. This holds whether or not the flag was already set.
- R4: A write that advances or restarts a handshake is never permitted while no window is open.
- R5: Completing the arming handshake opens a load window. In that window the first `PAGE_BYTES` writes (default 64) are permitted, and any further writes are suppressed.
- R6: A `prog_done` pulse closes an open window, and `prot_flag` stays 1. Ordinary writes after that are suppressed.
- R7: With `prot_flag` at 1 and no window open, no write is permitted.
- R8: The six consecutive writes AA to 1555, 55 to 0AAA, 80 to 1555, AA to 1555, 55 to 0AAA and 20 to 1555 clear `prot_flag` on the edge that takes the sixth write. Ordinary writes are permitted after that.
- R9: A write that does not match the next expected step returns the matcher to idle. That write is then judged as an ordinary write.
- R10: A mismatching write that itself equals the first step (AA to 1555) restarts the handshake at step one.
- R11: Inside an open window, writes are loaded as data even if they look like handshake steps. They neither advance the matcher nor change `prot_flag`.
- R12: A `prog_done` pulse while no window is open changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | One-cycle pulse marking a latched write cycle |
| wr_addr | input | 13 | Address of the write cycle |
| wr_data | input | 8 | Data byte of the write cycle |
| prog_done | input | 1 | Pulse from the array when its programming cycle ends |
| wr_permit | output | 1 | The current write may be committed to the array |
| prot_flag | output | 1 | Protection flag (register standing in for the nonvolatile bit) |

## Verification
Every cycle, the bound checker enforces these invariants:
- no permit without a write;
- no permit while protected outside a window;
- handshake lead bytes are never passed through;
- the flag rises only after an A0-to-1555 write and falls only after a 20-to-1555 write;
- the window counter stays bounded;
- a window implies the flag is set and closes on `prog_done`.

Only the directed scenarios can show that the full handshakes work in order. The same holds for the page limit landing exactly at 64 bytes, the restart on a repeated first step, a foreign write abandoning a handshake, and look-alike bytes inside a window being taken as data.

// File: rtl/wp_seq_guard.sv
module wp_seq_guard #(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 64,
  parameter logic [ADDR_W-1:0] KEY_A = 13'h1555,
  parameter logic [ADDR_W-1:0] KEY_B = 13'h0AAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              prog_done,
  output logic              wr_permit,
  output logic              prot_flag
);

  localparam int CNT_W = $clog2(PAGE_BYTES + 1);
  localparam logic [CNT_W-1:0] PAGE_CNT = CNT_W'(PAGE_BYTES);
  localparam logic [DATA_W-1:0] C_AA = DATA_W'(8'hAA);
  localparam logic [DATA_W-1:0] C_55 = DATA_W'(8'h55);
  localparam logic [DATA_W-1:0] C_A0 = DATA_W'(8'hA0);
  localparam logic [DATA_W-1:0] C_80 = DATA_W'(8'h80);
  localparam logic [DATA_W-1:0] C_20 = DATA_W'(8'h20);

  typedef enum logic [2:0] {
    ST_IDLE, ST_G1, ST_G2, ST_D3, ST_D4, ST_D5
  } step_t;

  step_t            step_q, step_d;
  logic             prot_q;
  logic             win_open;
  logic [CNT_W-1:0] win_cnt;
  logic             advance, fire_en, fire_dis;

  wire on_a = (wr_addr == KEY_A);
  wire on_b = (wr_addr == KEY_B);
  wire h_aa = on_a && (wr_data == C_AA);
  wire h_55 = on_b && (wr_data == C_55);
  wire h_a0 = on_a && (wr_data == C_A0);
  wire h_80 = on_a && (wr_data == C_80);
  wire h_20 = on_a && (wr_data == C_20);
  wire room = (win_cnt < PAGE_CNT);

  always_comb begin
    step_d   = step_q;
    advance  = 1'b0;
    fire_en  = 1'b0;
    fire_dis = 1'b0;
    if (wr_valid && !win_open) begin
      step_d  = h_aa ? ST_G1 : ST_IDLE;
      advance = h_aa;
      case (step_q)
        ST_G1: if (h_55) begin step_d = ST_G2; advance = 1'b1; end
        ST_G2: begin
          if (h_a0) begin
            step_d = ST_IDLE; advance = 1'b1; fire_en = 1'b1;
          end else if (h_80) begin
            step_d = ST_D3; advance = 1'b1;
          end
        end
        ST_D3: if (h_aa) step_d = ST_D4;
        ST_D4: if (h_55) begin step_d = ST_D5; advance = 1'b1; end
        ST_D5: if (h_20) begin step_d = ST_IDLE; advance = 1'b1; fire_dis = 1'b1; end
        default: ;
      endcase
    end
  end

  assign wr_permit = wr_valid && (win_open ? room : (!advance && !prot_q));
  assign prot_flag = prot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q   <= ST_IDLE;
      prot_q   <= 1'b0;
      win_open <= 1'b0;
      win_cnt  <= '0;
    end else begin
      step_q <= step_d;
      if (fire_en)
        prot_q <= 1'b1;
      else if (fire_dis)
        prot_q <= 1'b0;
      if (fire_en) begin
        win_open <= 1'b1;
        win_cnt  <= '0;
      end else if (win_open) begin
        if (prog_done)
          win_open <= 1'b0;
        if (wr_valid && room)
          win_cnt <= win_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/wp_seq_guard_chk.sv
module wp_seq_guard_chk #(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 64,
  parameter int CNT_W      = 7,
  parameter logic [ADDR_W-1:0] KEY_A = 13'h1555
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              prog_done,
  input logic              wr_permit,
  input logic              prot_flag,
  input logic              win_open,
  input logic [CNT_W-1:0]  win_cnt
);

  AST_NO_PERMIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |-> !wr_permit); // R2
  AST_PROT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_flag && !win_open) |-> !wr_permit); // R7
  AST_LEAD_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !win_open && wr_addr == KEY_A && wr_data == DATA_W'(8'hAA)) |-> !wr_permit); // R4
  AST_SET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prot_flag) |-> $past(wr_valid && wr_addr == KEY_A && wr_data == DATA_W'(8'hA0))); // R3
  AST_CLR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prot_flag) |-> $past(wr_valid && wr_addr == KEY_A && wr_data == DATA_W'(8'h20))); // R8
  AST_WIN_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (win_open && prog_done) |=> !win_open); // R6
  AST_WIN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    win_open |-> prot_flag); // R6
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    win_cnt <= CNT_W'(PAGE_BYTES)); // R5

endmodule

bind wp_seq_guard wp_seq_guard_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES),
  .CNT_W(CNT_W), .KEY_A(KEY_A)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .wr_data(wr_data), .prog_done(prog_done), .wr_permit(wr_permit),
  .prot_flag(prot_flag), .win_open(win_open), .win_cnt(win_cnt)
);

// File: tb/wp_seq_guard_tb.sv
module wp_seq_guard_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [12:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        prog_done = 1'b0;
  logic        wr_permit, prot_flag;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  wp_seq_guard u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .prog_done(prog_done), .wr_permit(wr_permit),
    .prot_flag(prot_flag)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [7:0] d, input logic exp, input string tag);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    #1 chk(tag, wr_permit, exp);
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); prog_done = 1'b1;
    @(negedge clk); prog_done = 1'b0;
  endtask

  task automatic arm(input string tag);
    wr(13'h1555, 8'hAA, 1'b0, tag);
    wr(13'h0AAA, 8'h55, 1'b0, tag);
    wr(13'h1555, 8'hA0, 1'b0, tag);
  endtask

  task automatic t_reset();
    chk("R1 flag after reset", prot_flag, 1'b0);
    wr(13'h0100, 8'h12, 1'b1, "R2 open write");
    @(negedge clk);
    chk("R2 no permit without write", wr_permit, 1'b0);
  endtask

  task automatic t_unprot_interrupt();
    wr(13'h1555, 8'hAA, 1'b0, "R4 lead byte consumed");
    wr(13'h0300, 8'h77, 1'b1, "R9 foreign write ordinary");
    wr(13'h0AAA, 8'h55, 1'b1, "R9 matcher back to idle");
    chk("R9 flag unchanged", prot_flag, 1'b0);
  endtask

  task automatic t_idle_done();
    pulse_done();
    chk("R12 flag after idle done", prot_flag, 1'b0);
    wr(13'h0101, 8'h01, 1'b1, "R12 write after idle done");
  endtask

  task automatic t_arm_load();
    arm("R4 arming step blocked");
    chk("R3 flag set", prot_flag, 1'b1);
    for (int i = 0; i < 3; i++) wr(13'h0040 + 13'(i), 8'(i), 1'b1, "R5 page byte");
    pulse_done();
    chk("R6 flag stays set", prot_flag, 1'b1);
    wr(13'h0050, 8'h99, 1'b0, "R6 write after window");
    wr(13'h0051, 8'h98, 1'b0, "R7 protected write");
  endtask

  task automatic t_page_limit();
    arm("R3 re-arm while set");
    chk("R3 flag still set", prot_flag, 1'b1);
    wr(13'h1555, 8'hAA, 1'b1, "R11 lookalike loaded");
    wr(13'h0AAA, 8'h55, 1'b1, "R11 lookalike loaded");
    wr(13'h1555, 8'h80, 1'b1, "R11 lookalike loaded");
    for (int i = 3; i < 64; i++) wr(13'h0080 + 13'(i), 8'(i), 1'b1, "R5 within page");
    wr(13'h00FF, 8'hEE, 1'b0, "R5 beyond page");
    chk("R11 flag unchanged", prot_flag, 1'b1);
    pulse_done();
    wr(13'h0002, 8'h02, 1'b0, "R7 after second window");
  endtask

  task automatic t_prot_interrupt();
    wr(13'h1555, 8'hAA, 1'b0, "R4 step one");
    wr(13'h0AAA, 8'h55, 1'b0, "R4 step two");
    wr(13'h0200, 8'h33, 1'b0, "R9 interrupt while protected");
    wr(13'h1555, 8'hA0, 1'b0, "R9 stale third step");
    wr(13'h0201, 8'h34, 1'b0, "R9 no window opened");
  endtask

  task automatic t_restart();
    wr(13'h1555, 8'hAA, 1'b0, "R10 first");
    wr(13'h1555, 8'hAA, 1'b0, "R10 repeat first");
    wr(13'h0AAA, 8'h55, 1'b0, "R10 second");
    wr(13'h1555, 8'hA0, 1'b0, "R10 third");
    wr(13'h0300, 8'h44, 1'b1, "R10 window opened");
    pulse_done();
  endtask

  task automatic t_disable();
    wr(13'h1555, 8'hAA, 1'b0, "R8 s1");
    wr(13'h0AAA, 8'h55, 1'b0, "R8 s2");
    wr(13'h1555, 8'h80, 1'b0, "R8 s3");
    chk("R8 flag mid handshake", prot_flag, 1'b1);
    wr(13'h1555, 8'hAA, 1'b0, "R8 s4");
    wr(13'h0AAA, 8'h55, 1'b0, "R8 s5");
    wr(13'h1555, 8'h20, 1'b0, "R8 s6");
    chk("R8 flag cleared", prot_flag, 1'b0);
    wr(13'h0400, 8'h55, 1'b1, "R8 open after clear");
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unprot_interrupt();
    t_idle_done();
    t_arm_load();
    t_page_limit();
    t_prot_interrupt();
    t_restart();
    t_disable();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule